// File: doc/BRIEF.md
# Modem Control and Status Register Pair

This block keeps the modem control byte and the modem status byte of a byte-wide serial port. Software writes the control byte to drive the request-to-send and data-terminal-ready outputs and two general-purpose output bits. It reads the status byte to see the present levels of the four modem input lines, together with sticky bits that record which lines have changed since the last read.

The four modem inputs come from outside the clock domain. They pass through a two-flop synchroniser. Each clock the synchronised levels are compared with the levels captured one clock earlier, and every difference is latched as a change bit. The ring-indicator change bit records only the ring line going from high to low. Reading the status byte clears the change bits at the next clock edge. A change that arrives on that same edge is still kept.

A loopback bit in the control byte routes four control bits back into the status read path, so software can test the port without external wiring. While loopback is on, the external request-to-send and data-terminal-ready outputs are held low. A pending output, which is the OR of the stored change bits, goes to the interrupt logic.

Top module: `modem_ctl_stat`

## Requirements
- R1: After reset the control byte reads 0x08, the status byte reads 0xB0 (carrier, data-set-ready and clear-to-send high, ring low, no change bits), both modem outputs are low and the pending output is low.
- R2: A control write stores only bits 4:0 of the written byte: bit 0 data-terminal-ready, bit 1 request-to-send, bit 2 general output 1, bit 3 general output 2, bit 4 loopback. Bits 7:5 of the control byte always read zero.
- R3: With loopback off, `rts_out` follows control bit 1 and `dtr_out` follows control bit 0. With loopback on, both outputs are low.
- R4: Status bits 7:4 report carrier, ring, data-set-ready and clear-to-send, in that order. A level applied to an input is visible in these bits after the third rising clock edge, and not after the second.
- R5: A change of the carrier, data-set-ready or clear-to-send line sets status bit 3, 1 or 0 respectively. The bit then stays set until a status read.
- R6: Status bit 2 is set only when the ring line goes from high to low. A rising ring line sets no change bit.
- R7: A status read with loopback off clears status bits 3:0 at the next edge and leaves bits 7:4 unchanged. A line change latched on that same edge is kept.
- R8: With loopback on, a status read returns general output 2 in bit 7, general output 1 in bit 6, data-terminal-ready in bit 5, request-to-send in bit 4, and zero in bits 3:0. Such a read clears no stored change bit, and the input lines keep being sampled.
- R9: `delta_pend` is the OR of the four stored change bits while loopback is off. It is low while loopback is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Write data |
| ctl_rdata | output | 8 | Control byte read data |
| stat_rd | input | 1 | Status read strobe; the read takes effect on the next edge |
| stat_rdata | output | 8 | Status byte read data |
| cts_in | input | 1 | Clear-to-send input, asynchronous |
| dsr_in | input | 1 | Data-set-ready input, asynchronous |
| dcd_in | input | 1 | Carrier-detect input, asynchronous |
| ri_in | input | 1 | Ring-indicator input, asynchronous |
| rts_out | output | 1 | Request-to-send output |
| dtr_out | output | 1 | Data-terminal-ready output |
| delta_pend | output | 1 | A stored change bit is set |

## Verification
The hardest case to reach from the ports is a status read that lands on the same edge as a new change bit. The input must be moved exactly two edges before the read strobe, so that the synchroniser delivers the change on the read edge. The stimulus first leaves an older change bit set, then applies such a timed change and checks that only the new change bit survives. A second hard case is a change that is stored while loopback hides it. The bench sets a change bit, enters loopback, reads the status byte and moves an input, then leaves loopback and expects both the old and the new change bit to be present.

// File: rtl/modem_ctl_stat.sv
module modem_ctl_stat #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [7:0] wr_data,
  output logic [7:0] ctl_rdata,
  input  logic       stat_rd,
  output logic [7:0] stat_rdata,
  input  logic       cts_in,
  input  logic       dsr_in,
  input  logic       dcd_in,
  input  logic       ri_in,
  output logic       rts_out,
  output logic       dtr_out,
  output logic       delta_pend
);

  localparam logic [3:0] LINE_IDLE = 4'b1011;
  localparam logic [4:0] CTL_INIT  = 5'b01000;

  logic [4:0] ctl_q;
  logic [SYNC_STAGES-1:0][3:0] sync_q;
  logic [3:0] lines_q, delta_q, now_lines, edge_bits, hit_bits;
  logic       loop_on;

  assign loop_on   = ctl_q[4];
  assign now_lines = sync_q[SYNC_STAGES-1];
  assign edge_bits = now_lines ^ lines_q;
  assign hit_bits  = {edge_bits[3], edge_bits[2] & lines_q[2], edge_bits[1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= {SYNC_STAGES{LINE_IDLE}};
    end else begin
      sync_q[0] <= {dcd_in, ri_in, dsr_in, cts_in};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q   <= CTL_INIT;
      lines_q <= LINE_IDLE;
      delta_q <= '0;
    end else begin
      if (ctl_wr) ctl_q <= wr_data[4:0];
      lines_q <= now_lines;
      delta_q <= ((stat_rd && !loop_on) ? 4'b0000 : delta_q) | hit_bits;
    end
  end

  assign ctl_rdata  = {3'b000, ctl_q};
  assign stat_rdata = loop_on ? {ctl_q[3], ctl_q[2], ctl_q[0], ctl_q[1], 4'b0000}
                              : {lines_q, delta_q};
  assign rts_out    = ctl_q[1] & ~loop_on;
  assign dtr_out    = ctl_q[0] & ~loop_on;
  assign delta_pend = (|delta_q) & ~loop_on;

  assert_ctl_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> ctl_rdata == ($past(wr_data) & 8'h1F));

  assert_outputs_quiet_in_loop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[4] |-> (!rts_out && !dtr_out));

  assert_delta_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((|delta_q) && !(stat_rd && !loop_on)) |=> (|delta_q));

  assert_ring_trailing_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(delta_q[2]) |-> ($past(lines_q[2]) && !lines_q[2]));

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !loop_on && now_lines == lines_q) |=> delta_q == 4'b0000);

  assert_loop_hides_delta_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[4] |-> (stat_rdata[3:0] == 4'b0000 && !delta_pend));

  assert_pend_tracks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_rdata[4] && stat_rdata[3:0] != 4'b0000) |-> delta_pend);

endmodule

// File: tb/modem_ctl_stat_tb.sv
module modem_ctl_stat_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_wr = 1'b0, stat_rd = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic cts_in = 1'b1, dsr_in = 1'b1, dcd_in = 1'b1, ri_in = 1'b0;
  logic [7:0] ctl_rdata, stat_rdata;
  logic rts_out, dtr_out, delta_pend;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  modem_ctl_stat dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .wr_data(wr_data),
    .ctl_rdata(ctl_rdata), .stat_rd(stat_rd), .stat_rdata(stat_rdata),
    .cts_in(cts_in), .dsr_in(dsr_in), .dcd_in(dcd_in), .ri_in(ri_in),
    .rts_out(rts_out), .dtr_out(dtr_out), .delta_pend(delta_pend)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int m_ctl, m_lines, m_delta;
  int pipe[$];

  function automatic int exp_stat();
    if ((m_ctl >> 4) & 1)
      return (((m_ctl >> 3) & 1) << 7) | (((m_ctl >> 2) & 1) << 6) |
             ((m_ctl & 1) << 5) | (((m_ctl >> 1) & 1) << 4);
    return (m_lines << 4) | m_delta;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int raw, now, chg;
    raw = {dcd_in, ri_in, dsr_in, cts_in};
    if (!rst_n) begin
      m_ctl = 8; m_lines = 11; m_delta = 0;
      pipe = {11, 11};
    end else begin
      now = pipe[0];
      void'(pipe.pop_front());
      pipe.push_back(raw);
      chg = now ^ m_lines;
      if (((m_lines >> 2) & 1) == 0) chg = chg & ~4;
      if (stat_rd && !((m_ctl >> 4) & 1)) m_delta = 0;
      m_delta = m_delta | chg;
      m_lines = now;
      if (ctl_wr) m_ctl = wr_data & 'h1F;
    end
    #1;
    if (rst_n) begin
      check("R2 model ctl", ctl_rdata, m_ctl);
      check("R4 model stat", stat_rdata, exp_stat());
      check("R3 model rts", rts_out, ((m_ctl >> 1) & 1) & ~((m_ctl >> 4) & 1));
      check("R3 model dtr", dtr_out, (m_ctl & 1) & ~((m_ctl >> 4) & 1));
      check("R9 model pend", delta_pend, (m_delta != 0) && !((m_ctl >> 4) & 1));
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctl(logic [7:0] v);
    ctl_wr = 1'b1; wr_data = v;
    tick(1);
    ctl_wr = 1'b0;
  endtask

  task automatic rd_stat();
    stat_rd = 1'b1;
    tick(1);
    stat_rd = 1'b0;
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    check("R1 ctl reset", ctl_rdata, 8'h08);
    check("R1 stat reset", stat_rdata, 8'hB0);
    check("R1 outputs reset", {rts_out, dtr_out, delta_pend}, 0);

    wr_ctl(8'hFF);
    check("R2 low five bits", ctl_rdata, 8'h1F);
    check("R3 quiet in loop", {rts_out, dtr_out}, 0);
    check("R8 loop all ones", stat_rdata, 8'hF0);

    wr_ctl(8'h03);
    check("R3 both on", {rts_out, dtr_out}, 2'b11);
    check("R1 idle stat", stat_rdata, 8'hB0);
    wr_ctl(8'h02);
    check("R3 rts only", {rts_out, dtr_out}, 2'b10);

    cts_in = 1'b0;
    tick(2);
    check("R4 not before third edge", stat_rdata, 8'hB0);
    tick(1);
    check("R4 R5 cts fall", stat_rdata, 8'hA1);
    check("R9 pend set", delta_pend, 1);
    tick(5);
    check("R5 sticky", stat_rdata, 8'hA1);
    rd_stat();
    check("R7 read clears", stat_rdata, 8'hA0);
    check("R9 pend clear", delta_pend, 0);

    ri_in = 1'b1;
    tick(3);
    check("R6 ring rise no delta", stat_rdata, 8'hE0);
    ri_in = 1'b0;
    tick(3);
    check("R6 ring fall", stat_rdata, 8'hA4);
    rd_stat();

    dcd_in = 1'b0;
    tick(3);
    check("R5 carrier change", stat_rdata, 8'h28);
    dsr_in = 1'b0;
    tick(2);
    rd_stat();
    check("R7 same-edge change kept", stat_rdata, 8'h02);

    wr_ctl(8'h15);
    check("R8 loop remap", stat_rdata, 8'h60);
    check("R9 pend low in loop", delta_pend, 0);
    check("R3 quiet in loop dtr", {rts_out, dtr_out}, 0);
    rd_stat();
    cts_in = 1'b1;
    tick(4);
    wr_ctl(8'h00);
    check("R8 deltas kept and lines sampled", stat_rdata, 8'h13);
    check("R9 pend after loop", delta_pend, 1);
    wr_ctl(8'h18);
    check("R8 out2 to bit7", stat_rdata, 8'h80);
    wr_ctl(8'h12);
    check("R8 rts to bit4", stat_rdata, 8'h10);
    tick(2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule